// File: doc/BRIEF.md
# UART Break and Parity Unit

This unit sits beside the shift registers of a UART data path and takes care of three line-level duties. On the transmit side it holds the serial line low for as long as a break control input is asserted, and it produces the parity bit for the outgoing data word. On the receive side it checks the parity bit of an incoming word against the word's own data bits, and it recognises a line break. A break is recognised when a framing error is followed by the receive line staying low for a set number of bit times.

Whether parity applies at all depends on the current setup. Parity is used only for 7-bit and 8-bit words in normal operation. It is suppressed in loopback mode, in attention mode, with 9-bit words, when parity is disabled, and when the parity select asks for none. The bit-time tick, the serial data and the stop-bit error strobe all come from the surrounding UART. Baud generation and shifting are done elsewhere.

Top module: `uart_brk_par`

## Requirements
- R1: One cycle after a sampling edge at which `brk_ctl` is 1, `tx_line` is 0. It stays 0 for as long as `brk_ctl` stays 1.
- R2: While `brk_ctl` is 0, `tx_line` repeats `tx_ser` with one cycle of delay.
- R3: `par_active` is 1 only when all of these hold: `par_en` is 1, `par_sel[1]` is 0, `fmt` is 00 (7 bits) or 01 (8 bits), and `mode` is 00 (normal). The encodings are: `fmt` 10 means 9 bits and 11 is reserved; `mode` 01 means loopback, 10 means attention and 11 is reserved; `par_sel` 00 means odd, 01 means even and 1x means none.
- R4: While `par_active` is 1, `tx_par` is the parity bit for bits [6:0] of `tx_word` (7-bit format) or bits [7:0] (8-bit format). With even parity, `tx_par` is the XOR of those bits. With odd parity, it is the inverse of that XOR. Word bits above the format width have no effect. While `par_active` is 0, `tx_par` is 0.
- R5: `par_err` is 1 in the cycle after a cycle in which three things are true: `rx_check` is 1, `par_active` is 1, and `rx_par_bit` differs from the parity computed from `rx_word` under the rule of R4. `par_err` is 0 in every other cycle.
- R6: Once `stop_missing` has been strobed with `rx_line` low, `brk_flag` rises in the cycle after the tenth following `bit_tick` cycle, as long as `rx_line` stays low throughout. After only nine such ticks, `brk_flag` is still 0.
- R7: A high level on `rx_line` cancels a break count that is in progress. Later ticks do not raise `brk_flag` until a new `stop_missing` strobe arrives.
- R8: Bit ticks with `rx_line` low never raise `brk_flag` unless a `stop_missing` strobe came before them.
- R9: `brk_flag` stays 1 until a `brk_clr` strobe, even if `rx_line` goes high. It is 0 in the cycle after `brk_clr`, and a clear takes priority over a set in the same cycle.
- R10: After reset, `tx_line` is 1, `brk_flag` is 0 and `par_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| fmt | input | 2 | Word format: 00 = 7 bits, 01 = 8 bits, 10 = 9 bits |
| mode | input | 2 | Mode: 00 = normal, 01 = loopback, 10 = attention |
| par_en | input | 1 | Parity enable |
| par_sel | input | 2 | Parity type: 00 = odd, 01 = even, 1x = none |
| brk_ctl | input | 1 | Break control: holds the transmit line low while set |
| tx_ser | input | 1 | Serial bit from the transmit shifter |
| tx_line | output | 1 | Registered transmit line |
| tx_word | input | 9 | Outgoing data word |
| tx_par | output | 1 | Parity bit for `tx_word` |
| par_active | output | 1 | Parity applies to the current setup |
| rx_line | input | 1 | Receive serial line |
| rx_word | input | 9 | Received data word |
| rx_par_bit | input | 1 | Received parity bit |
| rx_check | input | 1 | Strobe that requests a parity check of `rx_word` |
| par_err | output | 1 | One-cycle parity error pulse |
| stop_missing | input | 1 | Strobe reporting a missing stop bit |
| brk_clr | input | 1 | Clears the break flag |
| brk_flag | output | 1 | Sticky break-detected flag |

## Verification
Several behaviours are checked by the assertions on every cycle. They cover the transmit line being forced low under break control and passed through otherwise. They also check that parity is suppressed for 9-bit words and in the loopback and attention modes, that `tx_par` is zero whenever parity is off, and that a parity error only follows a check strobe. Finally, they check that the break flag only rises on a tick with the line low and drops after a clear. Some behaviours can only be shown by the bench's scenarios, because they depend on a sequence of events: the parity values themselves, swept over every format, mode, type and data word; the exact tenth-tick boundary of break detection; the cancellation by a high line; and the need for a prior stop-bit error.

// File: rtl/uart_bp_pkg.sv
// Package: shared encodings for the UART break and parity unit.
// Assumes the 2-bit field codes given in the brief.
package uart_bp_pkg;
    typedef enum logic [1:0] {
        FMT_7   = 2'b00,
        FMT_8   = 2'b01,
        FMT_9   = 2'b10,
        FMT_RSV = 2'b11
    } fmt_t;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'b00,
        MODE_LOOP   = 2'b01,
        MODE_ATTN   = 2'b10,
        MODE_RSV    = 2'b11
    } mode_t;

    typedef enum logic [1:0] {
        PSEL_ODD   = 2'b00,
        PSEL_EVEN  = 2'b01,
        PSEL_NONE0 = 2'b10,
        PSEL_NONE1 = 2'b11
    } psel_t;
endpackage

// File: rtl/bp_policy.sv
// Module: bp_policy
// Decides whether parity applies to the present format, mode and
// parity settings. Purely combinational. Reserved codes disable parity.
module bp_policy
    import uart_bp_pkg::*;
(
    input  fmt_t  fmt,
    input  mode_t mode,
    input  logic  par_en,
    input  psel_t par_sel,
    output logic  active,
    output logic  odd
);
    logic fmt_ok;
    logic mode_ok;
    logic sel_ok;

    // Qualify each setting separately, then combine them.
    always_comb begin
        fmt_ok  = (fmt == FMT_7) || (fmt == FMT_8);
        mode_ok = (mode == MODE_NORMAL);
        sel_ok  = (par_sel == PSEL_ODD) || (par_sel == PSEL_EVEN);
        active  = par_en && fmt_ok && mode_ok && sel_ok;
        odd     = (par_sel == PSEL_ODD);
    end
endmodule

// File: rtl/bp_parity.sv
// Module: bp_parity
// Computes the parity bit over the low NARROW or WIDE bits of a word.
// Higher bits are masked off. Combinational. Assumes NARROW < WIDE <= DW.
module bp_parity
    import uart_bp_pkg::*;
#(
    parameter int DW     = 9,
    parameter int NARROW = 7,
    parameter int WIDE   = 8
) (
    input  logic [DW-1:0] word,
    input  fmt_t          fmt,
    input  logic          odd,
    output logic          par_bit
);
    logic [DW-1:0] mask_narrow;
    logic [DW-1:0] mask_wide;

    // Build the two fixed masks, one bit at a time.
    for (genvar gi = 0; gi < DW; gi++) begin : g_mask
        assign mask_narrow[gi] = (gi < NARROW);
        assign mask_wide[gi]   = (gi < WIDE);
    end

    logic [DW-1:0] used;

    // Select the mask for the format, then reduce to a single bit.
    always_comb begin
        used    = word & ((fmt == FMT_7) ? mask_narrow : mask_wide);
        par_bit = (^used) ^ odd;
    end
endmodule

// File: rtl/bp_tx_break.sv
// Module: bp_tx_break
// Registers the transmit line and holds it low while break control is set.
// Resets to the idle (high) level.
module bp_tx_break (
    input  logic clk,
    input  logic rst_n,
    input  logic brk_ctl,
    input  logic tx_ser,
    output logic tx_line
);
    // Output register: forced low under break, otherwise the serial bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tx_line <= 1'b1;
        else
            tx_line <= brk_ctl ? 1'b0 : tx_ser;
    end
endmodule

// File: rtl/bp_rx_break.sv
// Module: bp_rx_break
// Detects a line break: after a stop-bit error, counts BRK_BITS bit ticks
// with the line low. A high line cancels the count. The flag is sticky until
// cleared, and a clear wins over a set in the same cycle.
module bp_rx_break #(
    parameter int BRK_BITS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic rx_line,
    input  logic stop_missing,
    input  logic brk_clr,
    output logic brk_flag
);
    localparam int CW = $clog2(BRK_BITS + 1);
    localparam logic [CW-1:0] LAST = CW'(BRK_BITS - 1);

    logic          armed;
    logic [CW-1:0] cnt;
    logic          hit;

    // A counting tick that completes the break window.
    always_comb hit = !rx_line && !stop_missing && armed && bit_tick && (cnt == LAST);

    // Arm on a stop-bit error, count low ticks, and cancel on a high line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (rx_line) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (stop_missing) begin
            armed <= 1'b1;
            cnt   <= '0;
        end else if (armed && bit_tick) begin
            if (cnt == LAST) begin
                armed <= 1'b0;
                cnt   <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Sticky flag with clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            brk_flag <= 1'b0;
        else if (brk_clr)
            brk_flag <= 1'b0;
        else if (hit)
            brk_flag <= 1'b1;
    end
endmodule

// File: rtl/uart_brk_par.sv
// Module: uart_brk_par
// Top level of the break and parity unit. It joins the parity policy, the
// transmit and receive parity calculators, transmit break forcing and
// receive break detection. Assumes the strobes are one cycle wide.
module uart_brk_par
    import uart_bp_pkg::*;
#(
    parameter int DW       = 9,
    parameter int NARROW   = 7,
    parameter int WIDE     = 8,
    parameter int BRK_BITS = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_tick,
    input  logic [1:0]    fmt,
    input  logic [1:0]    mode,
    input  logic          par_en,
    input  logic [1:0]    par_sel,
    input  logic          brk_ctl,
    input  logic          tx_ser,
    output logic          tx_line,
    input  logic [DW-1:0] tx_word,
    output logic          tx_par,
    output logic          par_active,
    input  logic          rx_line,
    input  logic [DW-1:0] rx_word,
    input  logic          rx_par_bit,
    input  logic          rx_check,
    output logic          par_err,
    input  logic          stop_missing,
    input  logic          brk_clr,
    output logic          brk_flag
);
    fmt_t  fmt_e;
    mode_t mode_e;
    psel_t sel_e;
    logic  odd;
    logic  tx_calc;
    logic  rx_calc;

    // Convert the port codes to the package types.
    always_comb begin
        fmt_e  = fmt_t'(fmt);
        mode_e = mode_t'(mode);
        sel_e  = psel_t'(par_sel);
    end

    bp_policy u_policy (
        .fmt     (fmt_e),
        .mode    (mode_e),
        .par_en  (par_en),
        .par_sel (sel_e),
        .active  (par_active),
        .odd     (odd)
    );

    bp_parity #(.DW(DW), .NARROW(NARROW), .WIDE(WIDE)) u_tx_par (
        .word    (tx_word),
        .fmt     (fmt_e),
        .odd     (odd),
        .par_bit (tx_calc)
    );

    bp_parity #(.DW(DW), .NARROW(NARROW), .WIDE(WIDE)) u_rx_par (
        .word    (rx_word),
        .fmt     (fmt_e),
        .odd     (odd),
        .par_bit (rx_calc)
    );

    // The transmit parity bit is gated by the policy.
    always_comb tx_par = par_active & tx_calc;

    // One-cycle error pulse after a qualified mismatching check.
    always_ff @(posedge clk) begin
        if (!rst_n)
            par_err <= 1'b0;
        else
            par_err <= rx_check && par_active && (rx_par_bit != rx_calc);
    end

    bp_tx_break u_tx_brk (
        .clk     (clk),
        .rst_n   (rst_n),
        .brk_ctl (brk_ctl),
        .tx_ser  (tx_ser),
        .tx_line (tx_line)
    );

    bp_rx_break #(.BRK_BITS(BRK_BITS)) u_rx_brk (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_tick     (bit_tick),
        .rx_line      (rx_line),
        .stop_missing (stop_missing),
        .brk_clr      (brk_clr),
        .brk_flag     (brk_flag)
    );
endmodule

// File: rtl/uart_brk_par_chk.sv
// Module: uart_brk_par_chk
// Checker for uart_brk_par, attached through bind. It observes ports only.
module uart_brk_par_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_tick,
    input logic [1:0] fmt,
    input logic [1:0] mode,
    input logic       brk_ctl,
    input logic       tx_ser,
    input logic       tx_line,
    input logic       tx_par,
    input logic       par_active,
    input logic       rx_line,
    input logic       rx_check,
    input logic       par_err,
    input logic       brk_clr,
    input logic       brk_flag
);
    p_brk_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        brk_ctl |=> !tx_line);

    p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !brk_ctl |=> (tx_line == $past(tx_ser)));

    p_no_par_9bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt[1] || mode != 2'b00) |-> !par_active);

    p_par_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !par_active |-> !tx_par);

    p_err_after_check_r5: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |-> $past(rx_check));

    p_flag_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(brk_flag) |-> $past(bit_tick && !rx_line));

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        brk_clr |=> !brk_flag);
endmodule

bind uart_brk_par uart_brk_par_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_tick   (bit_tick),
    .fmt        (fmt),
    .mode       (mode),
    .brk_ctl    (brk_ctl),
    .tx_ser     (tx_ser),
    .tx_line    (tx_line),
    .tx_par     (tx_par),
    .par_active (par_active),
    .rx_line    (rx_line),
    .rx_check   (rx_check),
    .par_err    (par_err),
    .brk_clr    (brk_clr),
    .brk_flag   (brk_flag)
);

// File: tb/uart_brk_par_test.sv
// Bench for uart_brk_par. Sweeps every parity setting and word, and runs the
// break scenarios. Inputs change on the falling edge and are sampled there too.
module uart_brk_par_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       bit_tick, par_en, brk_ctl, tx_ser, rx_line, rx_par_bit;
    logic       rx_check, stop_missing, brk_clr;
    logic [1:0] fmt, mode, par_sel;
    logic [8:0] tx_word, rx_word;
    logic       tx_line, tx_par, par_active, par_err, brk_flag;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_brk_par uut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .fmt(fmt), .mode(mode),
        .par_en(par_en), .par_sel(par_sel), .brk_ctl(brk_ctl), .tx_ser(tx_ser),
        .tx_line(tx_line), .tx_word(tx_word), .tx_par(tx_par),
        .par_active(par_active), .rx_line(rx_line), .rx_word(rx_word),
        .rx_par_bit(rx_par_bit), .rx_check(rx_check), .par_err(par_err),
        .stop_missing(stop_missing), .brk_clr(brk_clr), .brk_flag(brk_flag)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // Expected parity, computed by counting ones.
    function automatic logic exp_par(input logic [8:0] w, input int nb, input bit odd);
        int ones = 0;
        for (int i = 0; i < nb; i++) ones += w[i];
        return ((ones % 2) == 1) ^ odd;
    endfunction

    function automatic bit exp_active(input logic [1:0] f, input logic [1:0] m,
                                      input logic en, input logic [1:0] s);
        return en && (f == 2'b00 || f == 2'b01) && m == 2'b00 && !s[1];
    endfunction

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            bit_tick = 1'b1; cyc();
            bit_tick = 1'b0; cyc(); cyc();
        end
    endtask

    // Watchdog: an expired run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; bit_tick = 0; par_en = 0; brk_ctl = 0; tx_ser = 0;
        rx_line = 1; rx_par_bit = 0; rx_check = 0; stop_missing = 0; brk_clr = 0;
        fmt = 0; mode = 0; par_sel = 0; tx_word = 0; rx_word = 0;
        cyc(); cyc();
        check("R10 tx_line", tx_line, 1'b1);
        check("R10 brk_flag", brk_flag, 1'b0);
        check("R10 par_err", par_err, 1'b0);
        rst_n = 1'b1;
        cyc();

        // R1 and R2: break forcing and pass-through.
        for (int i = 0; i < 8; i++) begin
            brk_ctl = (i >= 2 && i < 6);
            tx_ser  = i[0];
            cyc();
            check(brk_ctl ? "R1 tx low" : "R2 tx follows", tx_line,
                  brk_ctl ? 1'b0 : tx_ser);
        end
        brk_ctl = 1'b0; tx_ser = 1'b1;
        cyc();
        check("R2 tx release", tx_line, 1'b1);

        // R3 and R4: every setting and every 9-bit word.
        for (int c = 0; c < 128; c++) begin
            fmt = c[1:0]; mode = c[3:2]; par_en = c[4]; par_sel = c[6:5];
            for (int w = 0; w < 512; w++) begin
                tx_word = w[8:0];
                #1;
                check("R3 par_active", par_active, exp_active(fmt, mode, par_en, par_sel));
                check("R4 tx_par", tx_par,
                      exp_active(fmt, mode, par_en, par_sel) ?
                      exp_par(tx_word, (fmt == 2'b00) ? 7 : 8, par_sel == 2'b00) : 1'b0);
            end
        end

        // R5: parity check pulse for every setting, with several words and both bits.
        for (int c = 0; c < 128; c++) begin
            fmt = c[1:0]; mode = c[3:2]; par_en = c[4]; par_sel = c[6:5];
            for (int k = 0; k < 8; k++) begin
                for (int b = 0; b < 2; b++) begin
                    rx_word = 9'((k * 83 + c * 7) % 512);
                    rx_par_bit = b[0];
                    rx_check = 1'b1;
                    cyc();
                    check("R5 pulse", par_err,
                          exp_active(fmt, mode, par_en, par_sel) &&
                          (rx_par_bit != exp_par(rx_word, (fmt == 2'b00) ? 7 : 8,
                                                  par_sel == 2'b00)));
                    rx_check = 1'b0;
                    cyc();
                    check("R5 one cycle", par_err, 1'b0);
                end
            end
        end

        // R8: ticks without a prior stop-bit error.
        rx_line = 1'b0;
        ticks(20);
        check("R8 no strobe", brk_flag, 1'b0);

        // R6: nine ticks are not enough, the tenth sets the flag.
        stop_missing = 1'b1; cyc(); stop_missing = 1'b0; cyc();
        ticks(9);
        check("R6 nine ticks", brk_flag, 1'b0);
        bit_tick = 1'b1; cyc(); bit_tick = 1'b0;
        check("R6 tenth tick", brk_flag, 1'b1);

        // R9: sticky while the line goes high, cleared by the strobe.
        rx_line = 1'b1; cyc(); cyc();
        check("R9 sticky", brk_flag, 1'b1);
        brk_clr = 1'b1; cyc(); brk_clr = 1'b0;
        check("R9 cleared", brk_flag, 1'b0);

        // R7: a high line cancels the count, and no new strobe follows.
        rx_line = 1'b0;
        stop_missing = 1'b1; cyc(); stop_missing = 1'b0; cyc();
        ticks(5);
        rx_line = 1'b1; cyc();
        rx_line = 1'b0; cyc();
        ticks(12);
        check("R7 cancelled", brk_flag, 1'b0);

        // R9: a clear in the same cycle as the completing tick wins.
        stop_missing = 1'b1; cyc(); stop_missing = 1'b0; cyc();
        ticks(9);
        bit_tick = 1'b1; brk_clr = 1'b1; cyc(); bit_tick = 1'b0; brk_clr = 1'b0;
        check("R9 clear priority", brk_flag, 1'b0);

        // R6: a fresh break after a clear is detected again.
        stop_missing = 1'b1; cyc(); stop_missing = 1'b0; cyc();
        ticks(10);
        check("R6 repeat", brk_flag, 1'b1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule